// File: doc/BRIEF.md
# InfoFrame Packet Scheduler

This block holds two auxiliary InfoFrames, a video-format frame (frame 0) and an audio frame (frame 1), and sends them as a byte stream toward a data-island packetizer. Software programs each frame through a write-only, byte-wide register port. It writes a control byte, three header bytes (type, version, payload length) and up to 27 payload bytes. The block works out each frame's checksum itself.

On every rising edge of vertical sync, the block sends each enabled frame whose checksum is current. It uses a valid/ready handshake and marks the final byte of each frame with a last flag. Frame 0 always goes before frame 1. A sync edge that arrives while a frame is being sent is held as a single pending request. A DVI-mode input blocks every frame.

Top module: `infoframe_sched`

## Requirements
- R1: After reset, both frames are disabled and `tx_valid_o` stays low, even when sync edges arrive.
- R2: A sent frame appears on `tx_data_o` as header bytes 0, 1 and 2, then the checksum, then payload bytes 1 to length. `tx_last_o` is high only on the final byte, and only while `tx_valid_o` is high.
- R3: The checksum byte is chosen so that the three header bytes, the checksum and the first `length` payload bytes add up to 0 mod 256.
- R4: A length written above 27 is stored as 27. Header byte 2 on the stream carries the stored (clamped) value.
- R5: Bit 1 of a frame's control register (register offset 0) enables that frame on every sync edge. When that bit is clear, the frame is not sent, whatever the other control bits hold.
- R6: While `dvi_mode_i` is high when a sync request is serviced, no frame is sent.
- R7: When both frames are enabled for the same sync edge, frame 0 is sent completely, then frame 1.
- R8: Any number of sync edges that arrive while frames are being sent produce exactly one further round of sending.
- R9: Any register write to a frame starts a recomputation of its checksum, at one byte per clock. A frame whose checksum is still being recomputed when a request is serviced is skipped for that request.
- R10: While `tx_valid_o` is high and `tx_ready_i` is low, `tx_valid_o` stays high and the byte position does not advance.
- R11: Writes to offset 4 (the checksum slot) do not change the checksum that is sent.
- R12: Header bytes 0, 1 and 2 are written at offsets 1, 2 and 3. Payload byte n (counting from 1) is written at offset 4+n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_frame_i | input | 1 | Frame select: 0 video-format, 1 audio |
| reg_addr_i | input | 5 | Register offset within the frame |
| reg_wdata_i | input | 8 | Write data |
| vsync_i | input | 1 | Vertical sync; a rising edge requests a round of sending |
| dvi_mode_i | input | 1 | Blocks all InfoFrame output |
| tx_ready_i | input | 1 | Downstream accepts a byte |
| tx_valid_o | output | 1 | Stream byte valid |
| tx_data_o | output | 8 | Stream byte |
| tx_last_o | output | 1 | Final byte of a frame |

## Verification
Frame 0 is swept through every payload length from 0 to 27. Each length gets its own payload pattern and a junk write to the checksum slot. Lengths alternate between a free-running sink and a stalling one. This separates errors in slot mapping, checksum accumulation and last-flag position from handshake errors. Further patterns cover:
- over-length writes;
- a control byte that has only bit 0 set;
- DVI mode;
- a write issued just before sync, which must drop only the frame written to;
- two sync pulses during a round, which must add exactly one more round.

The first three of these patterns tell clamping, enable decoding and suppression apart. The last two separate the skip rule and the pending latch from plain ordering.

// File: rtl/ifs_pkg.sv
`timescale 1ns/1ps
package ifs_pkg;
  localparam int OFS_CTRL = 0;
  localparam int OFS_HDR0 = 1;
  localparam int OFS_HDR1 = 2;
  localparam int OFS_LEN  = 3;
  localparam int OFS_CHK  = 4;
  localparam int OFS_PAY  = 5;
  localparam int CTRL_TX_BIT = 1;

  localparam logic [7:0] TYPE_BASE  = 8'h80;
  localparam logic [7:0] TYPE_VEND  = TYPE_BASE + 8'h01;
  localparam logic [7:0] TYPE_VIDEO = TYPE_BASE + 8'h02;
  localparam logic [7:0] TYPE_AUDIO = TYPE_BASE + 8'h04;
  localparam logic [7:0] VIDEO_VER  = 8'h02;
  localparam logic [7:0] VIDEO_LEN  = 8'h0D;
  localparam logic [7:0] AUDIO_VER  = 8'h01;
  localparam logic [7:0] AUDIO_LEN  = 8'h0A;
endpackage

// File: rtl/ifs_frame_regs.sv
`timescale 1ns/1ps
module ifs_frame_regs
  import ifs_pkg::*;
#(
  parameter int MAX_LEN = 27,
  parameter int AW      = 5,
  parameter int IW      = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic          en_o,
  output logic          busy_o,
  output logic [7:0]    len_o,
  output logic [7:0]    rd_data_o
);
  logic          en_q;
  logic [7:0]    hdr0_q, hdr1_q, len_q, chk_q;
  logic [7:0]    pay_q [MAX_LEN];
  logic          busy_q;
  logic [IW-1:0] sidx_q;
  logic [7:0]    acc_q;
  logic [7:0]    sbyte, acc_nxt;
  logic [IW-1:0] last_idx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      hdr0_q <= '0;
      hdr1_q <= '0;
      len_q  <= '0;
      for (int i = 0; i < MAX_LEN; i++) pay_q[i] <= '0;
    end else if (we_i) begin
      if (addr_i == AW'(OFS_CTRL)) en_q   <= wdata_i[CTRL_TX_BIT];
      if (addr_i == AW'(OFS_HDR0)) hdr0_q <= wdata_i;
      if (addr_i == AW'(OFS_HDR1)) hdr1_q <= wdata_i;
      if (addr_i == AW'(OFS_LEN))
        len_q <= (wdata_i > 8'(MAX_LEN)) ? 8'(MAX_LEN) : wdata_i;
      for (int i = 0; i < MAX_LEN; i++)
        if (addr_i == AW'(OFS_PAY + i)) pay_q[i] <= wdata_i;
    end
  end

  // serial checksum: walks hdr0, hdr1, len, (chk slot as 0), payload
  always_comb begin
    sbyte = 8'h00;
    case (sidx_q)
      IW'(0): sbyte = hdr0_q;
      IW'(1): sbyte = hdr1_q;
      IW'(2): sbyte = len_q;
      default: ;
    endcase
    for (int i = 0; i < MAX_LEN; i++)
      if (sidx_q == IW'(i + 4)) sbyte = pay_q[i];
  end

  assign last_idx = IW'(len_q) + IW'(3);
  assign acc_nxt  = acc_q + sbyte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sidx_q <= '0;
      acc_q  <= '0;
      chk_q  <= '0;
    end else if (we_i) begin
      busy_q <= 1'b1;
      sidx_q <= '0;
      acc_q  <= '0;
    end else if (busy_q) begin
      if (sidx_q == last_idx) begin
        chk_q  <= 8'h00 - acc_nxt;
        busy_q <= 1'b0;
      end else begin
        sidx_q <= sidx_q + IW'(1);
        acc_q  <= acc_nxt;
      end
    end
  end

  always_comb begin
    rd_data_o = 8'h00;
    case (rd_idx_i)
      IW'(0): rd_data_o = hdr0_q;
      IW'(1): rd_data_o = hdr1_q;
      IW'(2): rd_data_o = len_q;
      IW'(3): rd_data_o = chk_q;
      default: ;
    endcase
    for (int i = 0; i < MAX_LEN; i++)
      if (rd_idx_i == IW'(i + 4)) rd_data_o = pay_q[i];
  end

  assign en_o   = en_q;
  assign busy_o = busy_q;
  assign len_o  = len_q;

  logic [7:0] fsum;
  always_comb begin
    fsum = hdr0_q + hdr1_q + len_q + chk_q;
    for (int i = 0; i < MAX_LEN; i++)
      if (i < int'(len_q)) fsum = fsum + pay_q[i];
  end

  // R3
  chk_zero_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> (fsum == 8'h00));

  // R4
  len_clamp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_q <= 8'(MAX_LEN));
endmodule

// File: rtl/ifs_stream.sv
`timescale 1ns/1ps
module ifs_stream #(
  parameter int N  = 2,
  parameter int IW = 5,
  parameter int SW = (N > 1) ? $clog2(N) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                vsync_i,
  input  logic                dvi_mode_i,
  input  logic [N-1:0]        en_i,
  input  logic [N-1:0]        busy_i,
  input  logic [N-1:0][7:0]   len_i,
  input  logic [N-1:0][7:0]   rd_data_i,
  output logic [IW-1:0]       rd_idx_o,
  input  logic                tx_ready_i,
  output logic                tx_valid_o,
  output logic [7:0]          tx_data_o,
  output logic                tx_last_o
);
  logic          send_q, pend_q, vs_q;
  logic [SW-1:0] sel_q;
  logic [IW-1:0] idx_q;
  logic [N-1:0]  mask_q;
  logic [N-1:0]  elig;
  logic          vs_edge, is_last;

  function automatic logic [SW-1:0] first_of(input logic [N-1:0] m);
    first_of = '0;
    for (int i = N - 1; i >= 0; i--)
      if (m[i]) first_of = SW'(i);
  endfunction

  function automatic logic [N-1:0] bit_of(input logic [SW-1:0] s);
    bit_of = N'(1) << s;
  endfunction

  assign vs_edge = vsync_i & ~vs_q;
  assign elig    = en_i & ~busy_i & {N{~dvi_mode_i}};
  assign is_last = idx_q == (IW'(len_i[sel_q]) + IW'(3));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      send_q <= 1'b0;
      pend_q <= 1'b0;
      vs_q   <= 1'b0;
      sel_q  <= '0;
      idx_q  <= '0;
      mask_q <= '0;
    end else begin
      vs_q   <= vsync_i;
      pend_q <= vs_edge | (pend_q & send_q);
      if (!send_q) begin
        if (pend_q && |elig) begin
          send_q <= 1'b1;
          sel_q  <= first_of(elig);
          mask_q <= elig & ~bit_of(first_of(elig));
          idx_q  <= '0;
        end
      end else if (tx_ready_i) begin
        if (is_last) begin
          if (|mask_q) begin
            sel_q  <= first_of(mask_q);
            mask_q <= mask_q & ~bit_of(first_of(mask_q));
            idx_q  <= '0;
          end else begin
            send_q <= 1'b0;
          end
        end else begin
          idx_q <= idx_q + IW'(1);
        end
      end
    end
  end

  assign rd_idx_o   = idx_q;
  assign tx_valid_o = send_q;
  assign tx_data_o  = rd_data_i[sel_q];
  assign tx_last_o  = send_q & is_last;

  // R10
  hold_on_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(rd_idx_o) && $stable(sel_q));

  // R2
  last_needs_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_last_o |-> tx_valid_o);

  // R6
  dvi_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(send_q) |-> !$past(dvi_mode_i));

  // R7
  order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && tx_ready_i && tx_last_o && (|mask_q) |=> sel_q > $past(sel_q));

  // R8
  one_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q && !send_q |=> !pend_q || $past(vs_edge));
endmodule

// File: rtl/infoframe_sched.sv
`timescale 1ns/1ps
module infoframe_sched #(
  parameter int NUM_FRAMES = 2,
  parameter int MAX_LEN    = 27,
  localparam int FW = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam int AW = $clog2(MAX_LEN + 5),
  localparam int IW = $clog2(MAX_LEN + 4)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_we_i,
  input  logic [FW-1:0] reg_frame_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [7:0]    reg_wdata_i,
  input  logic          vsync_i,
  input  logic          dvi_mode_i,
  input  logic          tx_ready_i,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  output logic          tx_last_o
);
  logic [NUM_FRAMES-1:0]      en, busy;
  logic [NUM_FRAMES-1:0][7:0] len, rd_data;
  logic [IW-1:0]              rd_idx;

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_frame
    ifs_frame_regs #(.MAX_LEN(MAX_LEN), .AW(AW), .IW(IW)) regs_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (reg_we_i && (reg_frame_i == FW'(g))),
      .addr_i    (reg_addr_i),
      .wdata_i   (reg_wdata_i),
      .rd_idx_i  (rd_idx),
      .en_o      (en[g]),
      .busy_o    (busy[g]),
      .len_o     (len[g]),
      .rd_data_o (rd_data[g])
    );
  end

  ifs_stream #(.N(NUM_FRAMES), .IW(IW)) stream_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vsync_i    (vsync_i),
    .dvi_mode_i (dvi_mode_i),
    .en_i       (en),
    .busy_i     (busy),
    .len_i      (len),
    .rd_data_i  (rd_data),
    .rd_idx_o   (rd_idx),
    .tx_ready_i (tx_ready_i),
    .tx_valid_o (tx_valid_o),
    .tx_data_o  (tx_data_o),
    .tx_last_o  (tx_last_o)
  );
endmodule

// File: tb/infoframe_sched_tb_top.sv
`timescale 1ns/1ps
module infoframe_sched_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [0:0] frame = '0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       vsync = 1'b0;
  logic       dvi = 1'b0;
  logic       ready = 1'b1;
  logic       tx_valid, tx_last;
  logic [7:0] tx_data;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit bp_en = 1'b0;

  int m_hdr [2][3];
  int m_len [2];
  int m_pay [2][27];

  always #2 clk = ~clk;

  infoframe_sched dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_frame_i(frame),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .vsync_i(vsync),
    .dvi_mode_i(dvi), .tx_ready_i(ready), .tx_valid_o(tx_valid),
    .tx_data_o(tx_data), .tx_last_o(tx_last)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  task automatic wr(input int f, input int a, input int d);
    @(negedge clk);
    we = 1'b1; frame = 1'(f); addr = 5'(a); wdata = 8'(d);
    @(negedge clk);
    we = 1'b0;
    if (a >= 1 && a <= 2) m_hdr[f][a-1] = d & 8'hff;
    if (a == 3) m_len[f] = ((d & 8'hff) > 27) ? 27 : (d & 8'hff);
    if (a >= 5) m_pay[f][a-5] = d & 8'hff;
  endtask

  function automatic int exp_byte(input int f, input int k);
    int s;
    if (k < 2) return m_hdr[f][k];
    if (k == 2) return m_len[f];
    s = m_hdr[f][0] + m_hdr[f][1] + m_len[f];
    for (int i = 0; i < m_len[f]; i++) s += m_pay[f][i];
    if (k == 3) return (256 - (s % 256)) % 256;
    return m_pay[f][k-4];
  endfunction

  task automatic recv(input int f, input string rq);
    int n = m_len[f] + 4;
    for (int k = 0; k < n; k++) begin
      int w = 0;
      @(negedge clk);
      while (!(tx_valid && ready)) begin
        w++;
        if (w > 3000) begin
          chk(1'b0, {rq, " timeout"}, 0, 1);
          return;
        end
        @(negedge clk);
      end
      chk(tx_data == 8'(exp_byte(f, k)), rq, tx_data, exp_byte(f, k));
      chk(tx_last == (k == n - 1), "R2 last", tx_last, (k == n - 1));
    end
  endtask

  task automatic expect_idle(input int n, input string rq);
    repeat (n) begin
      @(negedge clk);
      chk(!tx_valid, rq, tx_valid, 0);
    end
  endtask

  task automatic pulse_vs();
    @(negedge clk); vsync = 1'b1;
    @(negedge clk); vsync = 1'b0;
  endtask

  task automatic settle();
    repeat (40) @(negedge clk);
  endtask

  // sink readiness pattern, changed just after each rising edge
  initial forever begin
    @(posedge clk); #1;
    cyc++;
    ready = bp_en ? ((cyc % 3) != 0) : 1'b1;
  end

  // R10: stalled byte must be held
  initial begin
    logic pv, pr;
    logic [7:0] pd;
    pv = 0; pr = 1; pd = 0;
    forever begin
      @(negedge clk);
      if (rst_n && pv && !pr) begin
        chk(tx_valid && tx_data == pd, "R10 hold", tx_data, pd);
      end
      pv = tx_valid; pr = ready; pd = tx_data;
    end
  end

  initial begin
    #(4 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int f = 0; f < 2; f++) begin
      m_len[f] = 0;
      for (int i = 0; i < 3; i++) m_hdr[f][i] = 0;
      for (int i = 0; i < 27; i++) m_pay[f][i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1
    chk(!tx_valid, "R1 reset valid", tx_valid, 0);
    pulse_vs();
    expect_idle(20, "R1 idle after reset");

    // R12: video frame with aspect byte 2 and code byte 4
    wr(0, 1, 8'h82); wr(0, 2, 8'h02); wr(0, 3, 8'h0D);
    for (int i = 0; i < 13; i++) wr(0, 5 + i, 8'h10 + i);
    wr(0, 6, 8'h28); wr(0, 8, 8'd16);
    wr(0, 0, 8'h02);
    settle();
    pulse_vs();
    recv(0, "R12 R3 video frame");
    expect_idle(10, "R5 audio disabled");

    // R7
    wr(1, 1, 8'h84); wr(1, 2, 8'h01); wr(1, 3, 8'h0A);
    for (int i = 0; i < 10; i++) wr(1, 5 + i, 8'hC0 ^ (i * 11));
    wr(1, 0, 8'h02);
    settle();
    pulse_vs();
    recv(0, "R7 first frame");
    recv(1, "R7 second frame");
    expect_idle(10, "R7 idle");

    // R8
    pulse_vs();
    fork
      begin recv(0, "R8 round1 f0"); recv(1, "R8 round1 f1"); end
      begin repeat (4) @(negedge clk); pulse_vs(); pulse_vs(); end
    join
    recv(0, "R8 round2 f0");
    recv(1, "R8 round2 f1");
    expect_idle(30, "R8 single extra round");

    // R9
    wr(1, 7, 8'h5C);
    pulse_vs();
    recv(0, "R9 unaffected frame");
    expect_idle(30, "R9 busy frame skipped");
    settle();
    pulse_vs();
    recv(0, "R9 recovered f0");
    recv(1, "R9 recovered f1");
    expect_idle(5, "R9 idle");

    // R5
    wr(0, 0, 8'h01); wr(1, 0, 8'hFD);
    settle();
    pulse_vs();
    expect_idle(40, "R5 bit1 clear");

    // R6
    wr(0, 0, 8'h02); wr(1, 0, 8'h02);
    settle();
    dvi = 1'b1;
    pulse_vs();
    expect_idle(60, "R6 dvi suppress");
    dvi = 1'b0;
    @(negedge clk);

    // R4
    wr(1, 0, 8'h00);
    wr(0, 3, 40);
    settle();
    pulse_vs();
    recv(0, "R4 clamp 40");
    wr(0, 3, 255);
    settle();
    pulse_vs();
    recv(0, "R4 clamp 255");
    expect_idle(5, "R4 idle");

    // R3 R11 R2: length sweep
    for (int len = 0; len <= 27; len++) begin
      bp_en = (len % 2) == 1;
      wr(0, 3, len);
      for (int i = 0; i < len; i++) wr(0, 5 + i, (len * 7 + i * 13 + 5) & 8'hff);
      wr(0, 4, 8'h5A);
      settle();
      pulse_vs();
      recv(0, "R3 R11 sweep");
      expect_idle(4, "R2 sweep idle");
    end
    bp_en = 1'b0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule